// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst-of-Two SRAM Core

This block is a synthesizable, cycle-accurate core for a static memory with one port for reads and one for writes. Every access moves two 18-bit beats, and the two beats of one access make up one 36-bit stored word. The core runs from a single clock whose every rising edge is one transfer slot. An internal phase bit makes the slots alternate. The first slot after reset is a K slot, and it is followed by a K# slot. The K# slot stands in for the opposite edge of a double-rate interface clock.

A single address bus carries both addresses at different times. The read address is taken in the K slot and the write address in the K# slot that follows. Commands are sampled only in K slots. The first write beat arrives in the K slot and the second in the K# slot. Each beat has its own two active-low byte enables. Read data comes back lower beat first, then upper beat, and a valid flag stands in for the output drivers. A write that starts in the same K slot as a read to the same address is forwarded into that read.

Top module: `qdr_sram_core`

## Requirements
- R1: `k_slot_o` is 1 before the first edge after reset, so that edge is a K slot. After that, `k_slot_o` alternates on every edge. Commands and the read address are sampled only on edges where `k_slot_o` was 1.
- R2: While reset is held, and after it is released, `dvalid_o` is 0 and `dout_o` is 0 until the first read data is driven.
- R3: A read command sampled at K edge n drives the lower 18 bits of the addressed word after edge n+2. It drives the upper 18 bits after edge n+3. `dvalid_o` is 1 after both of those edges.
- R4: For a write sampled at K edge n, the beat on `din_i` at edge n becomes word bits 17:0. The beat at edge n+1 becomes bits 35:18. The address on `addr_i` at edge n+1 selects the word. The word is stored at edge n+1.
- R5: Within each beat, `be_n_i[0]` low writes `din_i[8:0]` and `be_n_i[1]` low writes `din_i[17:9]`. A byte whose enable is high keeps its stored value.
- R6: Read commands on consecutive K edges give `dvalid_o` = 1 on every edge with no gap between bursts.
- R7: If a read and a write to the same address are sampled at the same K edge, the read returns the bytes being written. Masked bytes return the old stored value. The read latency stays the same.
- R8: A write sampled one K edge after a read to the same address does not affect that read, which returns the old contents.
- R9: On a K edge with no read burst due, `dvalid_o` falls to 0 after that edge.
- R10: When `wr_n_i` is high at a K edge, `din_i`, `be_n_i` and the following K# address change nothing in storage.
- R11: A read sampled at the K edge after a write has been stored returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock; every rising edge is one transfer slot |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Shared address: read address in K slots, write address in K# slots |
| rd_n_i | input | 1 | Active-low read command, sampled in K slots |
| wr_n_i | input | 1 | Active-low write command, sampled in K slots |
| din_i | input | 18 | Write data beat |
| be_n_i | input | 2 | Active-low byte enables for the current beat |
| dout_o | output | 18 | Read data beat |
| dvalid_o | output | 1 | Read data valid; stands in for driver enable |
| k_slot_o | output | 1 | High when the next edge is a K slot |

## Verification
The bench builds the core with a depth of 16 words, so the 4-bit address space is small. Random reads and writes therefore hit the same word often. This brings same-slot forwarding with mixed byte masks, writes one cycle behind a read, and read-after-write into frequent reach. The bench also covers back-to-back bursts alongside idle gaps, so valid must both stay continuous and fall at the right K edge.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BEAT_W  = 18;
  localparam int BYTE_W  = 9;
  localparam int BEAT_BY = BEAT_W / BYTE_W;
  localparam int WORD_W  = 2 * BEAT_W;
  localparam int WORD_BY = 2 * BEAT_BY;

  typedef logic [BEAT_W-1:0]  beat_t;
  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [WORD_BY-1:0] wmask_t;
  typedef logic [BEAT_BY-1:0] bmask_t;

  // per-byte select: mask bit set takes the new byte
  function automatic word_t byte_merge(input word_t nw, input word_t old, input wmask_t m);
    word_t r;
    for (int b = 0; b < WORD_BY; b++)
      r[b*BYTE_W +: BYTE_W] = m[b] ? nw[b*BYTE_W +: BYTE_W] : old[b*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/qdr_slot_phase.sv
module qdr_slot_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic kslot_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign kslot_o = ~ph_q;

  AST_PHASE_K_TO_KB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kslot_o |=> !kslot_o); // R1
  AST_PHASE_KB_TO_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kslot_o |=> kslot_o); // R1
endmodule

// File: rtl/qdr_write_path.sv
module qdr_write_path
  import qdr_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kslot_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_n_i,
  input  beat_t         din_i,
  input  bmask_t        be_n_i,
  output logic          commit_o,
  output logic [AW-1:0] waddr_o,
  output word_t         wdata_o,
  output wmask_t        wmask_o
);
  logic   pend_q;
  beat_t  lo_d_q;
  bmask_t lo_m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lo_d_q <= '0;
      lo_m_q <= '0;
    end else if (kslot_i) begin
      pend_q <= ~wr_n_i;
      if (!wr_n_i) begin
        lo_d_q <= din_i;
        lo_m_q <= ~be_n_i;
      end
    end else begin
      pend_q <= 1'b0;
    end
  end

  // second beat and write address arrive in the K# slot
  assign commit_o = pend_q && !kslot_i;
  assign waddr_o  = addr_i;
  assign wdata_o  = {din_i, lo_d_q};
  assign wmask_o  = {~be_n_i, lo_m_q};

  AST_COMMIT_IN_KB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !kslot_i); // R4
  AST_COMMIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(kslot_i && !wr_n_i)); // R4
  AST_IDLE_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kslot_i && wr_n_i) |=> !commit_o); // R10
endmodule

// File: rtl/qdr_array.sv
module qdr_array
  import qdr_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  wmask_t        wmask_i,
  input  logic [AW-1:0] raddr_i,
  output word_t         rdata_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= byte_merge(wdata_i, mem_q[waddr_i], wmask_i);
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qdr_read_path.sv
module qdr_read_path
  import qdr_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kslot_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_n_i,
  input  logic          commit_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  wmask_t        wmask_i,
  input  word_t         mem_rd_i,
  output logic [AW-1:0] raddr_o,
  output beat_t         dout_o,
  output logic          dvalid_o
);
  logic          pend_q, issue_q, hi_q, valid_q;
  logic [AW-1:0] raddr_q;
  word_t         word_q;
  beat_t         dout_q;
  logic          fwd_hit;
  word_t         fetch;

  // forward only a write that started in the same K slot as this read
  assign fwd_hit = pend_q && commit_i && (waddr_i == raddr_q);
  assign fetch   = byte_merge(wdata_i, mem_rd_i, fwd_hit ? wmask_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      issue_q <= 1'b0;
      hi_q    <= 1'b0;
      valid_q <= 1'b0;
      raddr_q <= '0;
      word_q  <= '0;
      dout_q  <= '0;
    end else if (kslot_i) begin
      pend_q  <= ~rd_n_i;
      if (!rd_n_i) raddr_q <= addr_i;
      issue_q <= 1'b0;
      if (issue_q) begin
        dout_q  <= word_q[BEAT_W-1:0];
        valid_q <= 1'b1;
        hi_q    <= 1'b1;
      end else begin
        valid_q <= 1'b0;
        hi_q    <= 1'b0;
      end
    end else begin
      pend_q  <= 1'b0;
      issue_q <= pend_q;
      if (pend_q) word_q <= fetch;
      if (hi_q)   dout_q <= word_q[WORD_W-1:BEAT_W];
      hi_q    <= 1'b0;
    end
  end

  assign raddr_o  = raddr_q;
  assign dout_o   = dout_q;
  assign dvalid_o = valid_q;

  AST_LOWER_ON_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kslot_i && issue_q) |=> dvalid_o); // R3
  AST_UPPER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kslot_i && dvalid_o) |=> dvalid_o); // R3
  AST_DROP_ON_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kslot_i && !issue_q) |=> !dvalid_o); // R9
  AST_RISE_ONLY_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dvalid_o) |-> !kslot_i); // R3
endmodule

// File: rtl/qdr_sram_core.sv
module qdr_sram_core
  import qdr_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                rd_n_i,
  input  logic                wr_n_i,
  input  logic [BEAT_W-1:0]   din_i,
  input  logic [BEAT_BY-1:0]  be_n_i,
  output logic [BEAT_W-1:0]   dout_o,
  output logic                dvalid_o,
  output logic                k_slot_o
);
  logic          kslot;
  logic          commit;
  logic [AW-1:0] waddr, raddr;
  word_t         wdata, mem_rd;
  wmask_t        wmask;

  qdr_slot_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kslot_o (kslot)
  );

  qdr_write_path #(.AW(AW)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kslot_i  (kslot),
    .addr_i   (addr_i),
    .wr_n_i   (wr_n_i),
    .din_i    (din_i),
    .be_n_i   (be_n_i),
    .commit_o (commit),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .wmask_o  (wmask)
  );

  qdr_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .wmask_i (wmask),
    .raddr_i (raddr),
    .rdata_o (mem_rd)
  );

  qdr_read_path #(.AW(AW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kslot_i  (kslot),
    .addr_i   (addr_i),
    .rd_n_i   (rd_n_i),
    .commit_i (commit),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .wmask_i  (wmask),
    .mem_rd_i (mem_rd),
    .raddr_o  (raddr),
    .dout_o   (dout_o),
    .dvalid_o (dvalid_o)
  );

  assign k_slot_o = kslot;
endmodule

// File: tb/sim_qdr_sram_core.sv
module sim_qdr_sram_core;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int MAXE  = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic [AW-1:0] addr;
  logic          rd_n, wr_n;
  logic [17:0]   din;
  logic [1:0]    be_n;
  logic [17:0]   dout;
  logic          dvalid, kslot;

  qdr_sram_core #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .din_i(din), .be_n_i(be_n), .dout_o(dout), .dvalid_o(dvalid), .k_slot_o(kslot)
  );

  logic [35:0] mdl [DEPTH];
  logic        exp_v [MAXE];
  logic [17:0] exp_d [MAXE];
  string       exp_t [MAXE];
  int e = 0, checks = 0, fails = 0, cyc_cnt = 0;
  bit done = 0;

  function automatic logic [35:0] merge(input logic [35:0] nw, input logic [35:0] old,
                                        input logic [3:0] m);
    logic [35:0] r;
    for (int b = 0; b < 4; b++) r[b*9 +: 9] = m[b] ? nw[b*9 +: 9] : old[b*9 +: 9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", tag, e, act, expv);
    end
  endtask

  task automatic edge_check();
    check("R1", {35'd0, kslot}, {35'd0, (e % 2) == 1});
    if (e < MAXE) begin
      check(exp_t[e], {35'd0, dvalid}, {35'd0, exp_v[e]});
      if (exp_v[e]) check(exp_t[e], {18'd0, dout}, {18'd0, exp_d[e]});
    end
  endtask

  task automatic run_slot(input logic [AW-1:0] a, input logic rn, input logic wn,
                          input logic [17:0] d, input logic [1:0] bn);
    addr = a; rd_n = rn; wr_n = wn; din = d; be_n = bn;
    @(posedge clk);
    @(negedge clk);
    edge_check();
    e++;
  endtask

  task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa,
                     input logic [17:0] d0, input logic [1:0] b0,
                     input logic [17:0] d1, input logic [1:0] b1, input string tag);
    logic [35:0] w;
    run_slot(ra, ~rd, ~wr, wr ? d0 : 18'($urandom), wr ? ~b0 : 2'($urandom));
    // e now indexes the K# edge
    if (rd) begin
      w = mdl[ra];
      if (wr && wa == ra) w = merge({d1, d0}, w, {b1, b0});
      if (e + 2 < MAXE) begin
        exp_v[e+1] = 1'b1; exp_d[e+1] = w[17:0];  exp_t[e+1] = tag;
        exp_v[e+2] = 1'b1; exp_d[e+2] = w[35:18]; exp_t[e+2] = tag;
      end
    end
    if (wr) mdl[wa] = merge({d1, d0}, mdl[wa], {b1, b0});
    run_slot(wr ? wa : AW'($urandom), 1'($urandom), 1'($urandom),
             wr ? d1 : 18'($urandom), wr ? ~b1 : 2'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7731));
    for (int i = 0; i < MAXE; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R9"; end
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    rst_ni = 1'b0; addr = '0; rd_n = 1'b1; wr_n = 1'b1; din = '0; be_n = 2'b11;
    repeat (3) @(negedge clk);
    check("R2", {34'd0, dvalid, kslot}, 36'd1);
    check("R2", {18'd0, dout}, 36'd0);
    rst_ni = 1'b1;
    check("R2", {35'd0, dvalid}, 36'd0);
    // R4: beat order and K# address
    cyc(0, 4'd1, 1, 4'd3, 18'h12345, 2'b11, 18'h2abcd, 2'b11, "R4");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 0, "R4");
    // R11: read right after store
    cyc(0, 4'd0, 1, 4'd9, 18'h0beef, 2'b11, 18'h3cafe, 2'b11, "R11");
    cyc(1, 4'd9, 0, 4'd0, 0, 0, 0, 0, "R11");
    // R5: per-beat byte masks
    cyc(0, 4'd0, 1, 4'd3, 18'h3ffff, 2'b01, 18'h00000, 2'b10, "R5");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 0, "R5");
    // R7: same-slot forwarding with mixed masks
    cyc(1, 4'd3, 1, 4'd3, 18'h15555, 2'b10, 18'h0aaaa, 2'b01, "R7");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 0, "R7");
    // R8: write one cycle behind a read
    cyc(1, 4'd9, 0, 4'd0, 0, 0, 0, 0, "R8");
    cyc(0, 4'd0, 1, 4'd9, 18'h11111, 2'b11, 18'h22222, 2'b11, "R8");
    cyc(1, 4'd9, 0, 4'd0, 0, 0, 0, 0, "R11");
    // R6: back-to-back bursts
    for (int i = 0; i < 4; i++) cyc(1, AW'(i + 8), 0, 4'd0, 0, 0, 0, 0, "R6");
    // R10: deselected write with junk data
    cyc(0, 4'd0, 0, 4'd3, 18'h3ffff, 2'b11, 18'h3ffff, 2'b11, "R10");
    cyc(0, 4'd0, 0, 4'd9, 18'h3ffff, 2'b11, 18'h3ffff, 2'b11, "R10");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 0, "R10");
    cyc(1, 4'd9, 0, 4'd0, 0, 0, 0, 0, "R10");
    // R9: idle after burst
    cyc(0, 4'd0, 0, 4'd0, 0, 0, 0, 0, "R9");
    cyc(0, 4'd0, 0, 4'd0, 0, 0, 0, 0, "R9");
    // random mix; small address space forces collisions
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom), AW'($urandom), 1'($urandom), AW'($urandom),
          18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom), "R3");
    for (int i = 0; i < 4; i++) cyc(0, 4'd0, 0, 4'd0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (!done && cyc_cnt < 20000) begin
      @(posedge clk);
      cyc_cnt++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule